// File: doc/BRIEF.md
# Base-Bounds Address Translator

This block turns a 32-bit virtual address into a physical address without a TLB. The lower half of the address space is the user region. There, every access is checked against a bound and then relocated by a base. Instruction fetches use one base/bound pair, and loads and stores use a second pair. The upper half is reserved for kernel mode and is split into three fixed segments:

- a cached window that folds onto the first 512 MB of physical memory;
- an uncached window that folds onto the same 512 MB;
- a top gigabyte that passes through unchanged.

A request gives the virtual address, the access kind and the current privilege mode. One clock later the block returns a response valid flag and one of two results. For a legal access it returns the physical address and a cacheable flag. For an illegal access it raises an address fault, tags the fault with the access kind and latches the faulting address. Software loads the four relocation registers through a simple write port.

Top module: `addr_relocator`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and `bad_vaddr` are zero and all four relocation registers hold zero. A user fetch of address 0 therefore translates to 0, and a user fetch of address 4 faults.
- R2: When `reg_we` is high, the register picked by `reg_sel` is written at the clock edge. The select codes are 0 = fetch base, 1 = fetch bound, 2 = data base, 3 = data bound.
- R3: Access kind 0 (fetch) uses the fetch base/bound pair. Kinds 1 (load) and 2 (store) use the data pair. Kind 3 is never driven.
- R4: For an address with bit 31 clear that is unsigned less than or equal to the relevant bound, `rsp_paddr` is the address plus the base, modulo 2^32. `rsp_cacheable` is 1 in this case. This holds in both modes.
- R5: An address with bit 31 clear that is above the relevant bound raises `rsp_fault`, and `rsp_fault_kind` equals the request's access kind.
- R6: In user mode (`req_kernel` = 0), any address with bit 31 set raises `rsp_fault`.
- R7: In kernel mode, addresses 0x80000000 to 0x9FFFFFFF map to the address with bits 31:29 cleared, and `rsp_cacheable` is 1.
- R8: In kernel mode, addresses 0xA0000000 to 0xBFFFFFFF map to the address with bits 31:29 cleared, and `rsp_cacheable` is 0.
- R9: In kernel mode, addresses 0xC0000000 to 0xFFFFFFFF map to themselves, and `rsp_cacheable` is 1.
- R10: The response appears exactly one cycle after the request. `rsp_valid` is high exactly one cycle after `req_valid` was high, and `rsp_fault` is never high without `rsp_valid`.
- R11: `bad_vaddr` takes the faulting virtual address in the same cycle that `rsp_fault` is raised. It holds its value in every other cycle.
- R12: A request in the same cycle as a register write is translated with the value the register held before that write.
- R13: During a fault, `rsp_paddr` is 0 and `rsp_cacheable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Relocation register write strobe |
| reg_sel | input | 2 | Register select: 0 fetch base, 1 fetch bound, 2 data base, 3 data bound |
| reg_wdata | input | 32 | Register write value |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_fault | output | 1 | Address error |
| rsp_fault_kind | output | 2 | Access kind of the request that produced this response |
| bad_vaddr | output | 32 | Last faulting virtual address |

## Verification
The assertions assume that `req_kind` never carries code 3, and that the request inputs are stable around the clock edge. The stimulus keeps to both: it changes inputs only on the falling edge and draws access kinds from 0 to 2. The bound comparisons are exercised at exactly the bound, one above it, and across the 32-bit wrap of the relocation add. Register writes are also driven in the same cycle as requests, so that the old-value rule is visible at the ports.

// File: rtl/addr_relocator.sv
module addr_relocator #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic [1:0]    req_kind,
  input  logic          req_kernel,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_cacheable,
  output logic          rsp_fault,
  output logic [1:0]    rsp_fault_kind,
  output logic [AW-1:0] bad_vaddr
);
  localparam int SEGW = 3;
  localparam int OFFW = AW - SEGW;

  logic [AW-1:0] rel_regs [4];
  logic [AW-1:0] base, bound, pa_c;
  logic          fault_c, cach_c;
  logic [SEGW-1:0] seg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < 4; i++) rel_regs[i] <= '0;
    else if (reg_we) rel_regs[reg_sel] <= reg_wdata;

  assign base  = (req_kind == 2'd0) ? rel_regs[0] : rel_regs[2];
  assign bound = (req_kind == 2'd0) ? rel_regs[1] : rel_regs[3];
  assign seg   = req_vaddr[AW-1 -: SEGW];

  always_comb begin
    fault_c = 1'b0;
    cach_c  = 1'b1;
    pa_c    = req_vaddr;
    if (!req_vaddr[AW-1]) begin
      if (req_vaddr <= bound) pa_c = req_vaddr + base;
      else fault_c = 1'b1;
    end else if (!req_kernel) begin
      fault_c = 1'b1;
    end else if (!seg[1]) begin
      pa_c   = {{SEGW{1'b0}}, req_vaddr[OFFW-1:0]};
      cach_c = ~seg[0];
    end
    if (fault_c) begin
      pa_c   = '0;
      cach_c = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_cacheable  <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_fault_kind <= 2'd0;
      bad_vaddr      <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_paddr      <= pa_c;
      rsp_cacheable  <= cach_c;
      rsp_fault      <= req_valid & fault_c;
      rsp_fault_kind <= req_kind;
      if (req_valid && fault_c) bad_vaddr <= req_vaddr;
    end

  assert_fault_has_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid);
  assert_user_high_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_kernel && req_vaddr[AW-1] |=> rsp_fault);
  assert_kernel_low_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kernel && req_vaddr[AW-1 -: 2] == 2'b10 |=> !rsp_fault && rsp_paddr[AW-1 -: SEGW] == '0);
  assert_uncached_seg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kernel && req_vaddr[AW-1 -: SEGW] == 3'b101 |=> !rsp_cacheable);
  assert_top_identity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kernel && req_vaddr[AW-1 -: 2] == 2'b11 |=> rsp_paddr == $past(req_vaddr) && rsp_cacheable);
  assert_bad_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> bad_vaddr == $past(req_vaddr));
  assert_bad_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> $stable(bad_vaddr));
  assert_fault_zeroes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0 && !rsp_cacheable);
  assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_kind != 2'd3);
endmodule

// File: tb/test_addr_relocator.sv
module test_addr_relocator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_kernel = 1'b0;
  logic        rsp_valid, rsp_cacheable, rsp_fault;
  logic [31:0] rsp_paddr, bad_vaddr;
  logic [1:0]  rsp_fault_kind;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_regs [4];
  logic [31:0] m_bad;

  always #2 clk = ~clk;

  addr_relocator i_addr_relocator (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind), .req_kernel(req_kernel),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
    .rsp_fault(rsp_fault), .rsp_fault_kind(rsp_fault_kind), .bad_vaddr(bad_vaddr));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [1:0] sel, input logic [31:0] wd,
                      input bit v, input logic [31:0] va, input logic [1:0] k,
                      input bit kern, input string tag);
    logic [31:0] e_pa, b, bd;
    bit e_fault, e_cach;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    req_valid = v; req_vaddr = va; req_kind = k; req_kernel = kern;
    b  = (k == 2'd0) ? m_regs[0] : m_regs[2];
    bd = (k == 2'd0) ? m_regs[1] : m_regs[3];
    e_fault = 0; e_cach = 1; e_pa = va;
    if (va < 32'h8000_0000) begin
      if (va <= bd) e_pa = va + b; else e_fault = 1;
    end else if (!kern) e_fault = 1;
    else if (va < 32'hA000_0000) e_pa = va - 32'h8000_0000;
    else if (va < 32'hC000_0000) begin e_pa = va - 32'hA000_0000; e_cach = 0; end
    if (e_fault) begin e_pa = 0; e_cach = 0; end
    if (v && e_fault) m_bad = va;
    if (we) m_regs[sel] = wd;
    @(negedge clk);
    chk(tag, "rsp_valid (R10)", {31'd0, rsp_valid}, {31'd0, v});
    chk(tag, "rsp_fault", {31'd0, rsp_fault}, {31'd0, v && e_fault});
    chk(tag, "bad_vaddr (R11)", bad_vaddr, m_bad);
    if (v) begin
      chk(tag, "rsp_paddr", rsp_paddr, e_pa);
      chk(tag, "rsp_cacheable", {31'd0, rsp_cacheable}, {31'd0, e_cach});
      if (e_fault) chk(tag, "rsp_fault_kind", {30'd0, rsp_fault_kind}, {30'd0, k});
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
    m_bad = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1", "reset rsp_fault", {31'd0, rsp_fault}, 32'd0);
    chk("R1", "reset bad_vaddr", bad_vaddr, 32'd0);
    step(0, 0, 0, 1, 32'h0, 2'd0, 0, "R1");
    step(0, 0, 0, 1, 32'h4, 2'd0, 0, "R1");
    step(1, 2'd0, 32'h1000_0000, 0, 0, 0, 0, "R2");
    step(1, 2'd1, 32'h0000_FFFF, 0, 0, 0, 0, "R2");
    step(1, 2'd2, 32'h2000_0000, 0, 0, 0, 0, "R2");
    step(1, 2'd3, 32'h0001_0000, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 32'h100, 2'd0, 0, "R3");
    step(0, 0, 0, 1, 32'h100, 2'd1, 0, "R3");
    step(0, 0, 0, 1, 32'h1_0000, 2'd2, 0, "R4");
    step(0, 0, 0, 1, 32'hFFFF, 2'd0, 0, "R4");
    step(0, 0, 0, 1, 32'h1_0000, 2'd0, 0, "R5");
    step(0, 0, 0, 1, 32'h1_0001, 2'd2, 0, "R5/R13");
    step(0, 0, 0, 1, 32'h100, 2'd0, 1, "R4");
    step(1, 2'd2, 32'hF000_0000, 0, 0, 0, 0, "R2");
    step(1, 2'd3, 32'h7FFF_FFFF, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 32'h2000_0000, 2'd1, 0, "R4");
    step(0, 0, 0, 1, 32'h8000_0000, 2'd1, 0, "R6");
    step(0, 0, 0, 1, 32'hFFFF_FFFC, 2'd0, 0, "R6");
    step(0, 0, 0, 1, 32'h9234_5678, 2'd1, 1, "R7");
    step(0, 0, 0, 1, 32'h8000_0000, 2'd2, 1, "R7");
    step(0, 0, 0, 1, 32'hB000_0010, 2'd1, 1, "R8");
    step(0, 0, 0, 1, 32'hA000_0000, 2'd0, 1, "R8");
    step(0, 0, 0, 1, 32'hC000_0000, 2'd0, 1, "R9");
    step(0, 0, 0, 1, 32'hFFFF_FFFF, 2'd2, 1, "R9");
    step(1, 2'd1, 32'h0, 1, 32'h100, 2'd0, 0, "R12");
    step(0, 0, 0, 1, 32'h100, 2'd0, 0, "R12");
    step(0, 0, 0, 0, 32'h100, 2'd0, 0, "R10");
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va;
      bit w;
      va = $urandom;
      if (($urandom % 3) != 0) va[31] = 1'b0;
      if (($urandom % 2) != 0) va = va & 32'h8003_FFFF;
      w = ($urandom % 5) == 0;
      step(w, 2'($urandom), $urandom & 32'h0003_FFFF, ($urandom % 4) != 0,
           va, 2'($urandom % 3), 1'($urandom), "R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule